// File: doc/BRIEF.md
# USB Host Port Suspend and Reset Controller

This block holds the per-port control and status state that sits behind a host-mode port status register. Software writes three control fields: suspend, force-resume and port-reset. The block turns these writes into a timed bus-reset request and a suspend state machine. A bus reset clears itself when its programmed duration has run out. A suspend request that arrives in the middle of a bus transaction takes effect only once that transaction has finished. While the port is suspended, downstream traffic is gated off, with one exception: a port reset can still be driven, and the port can still detect resume.

The readback word also carries two read-only fields. One is the registered D+/D- line levels. The other is the high-speed flag reported by the attached-device detector. When port power is removed, the reset and suspend state is cleared and both of those bits read 0.

The block has two state machines. The bus-reset timer has the states `RT_IDLE` and `RT_DRIVE`, with the transitions *start* (IDLE→DRIVE on an accepted reset write), *expire* (DRIVE→IDLE when the count reaches zero) and *abort* (DRIVE→IDLE when power is lost). The suspend machine has the states `SP_ACTIVE`, `SP_PENDING` and `SP_SUSPENDED`. Its transitions are:
- *enter* (ACTIVE→SUSPENDED when the link is idle);
- *defer* (ACTIVE→PENDING when a transaction is busy);
- *settle* (PENDING→SUSPENDED when the transaction ends);
- *resume* (PENDING or SUSPENDED→ACTIVE on a force-resume 1→0 edge);
- *cancel* (any state→ACTIVE on a port-reset write or on loss of power).

Top module: `usb_port_ctl`

## Requirements
- R1: A write with bit 2 (port reset) set while port power is 1 and no reset is running raises `drive_reset` on the next cycle, and readback bit 2 then reads 1.
- R2: `drive_reset` stays high for exactly `RST_CYCLES` cycles and then falls by itself, and readback bit 2 returns to 0 with it. A write with bit 2 clear has no effect on a running reset.
- R3: While `port_power` is 0, readback bits 0 (suspend) and 2 (port reset) read 0. A power loss also aborts a running reset and leaves the suspend machine in its active state.
- R4: A write with bit 0 (suspend) set, made while the port is enabled, idle and not resetting, makes readback bit 0 and `block_traffic` read 1 on the next cycle.
- R5: If `xfer_busy` is 1 when suspend is requested, readback bit 0 and `block_traffic` stay 0 until `xfer_busy` is seen low. Both then read 1 one cycle later.
- R6: A write with bit 0 clear leaves the suspend state unchanged. A write that takes bit 1 (force resume) from 1 to 0 clears suspend, and also clears a pending suspend, on the next cycle.
- R7: A suspend write made while `port_enable` is 0 is ignored, and readback bit 0 stays 0.
- R8: A port-reset write made while suspended or pending clears suspend and `block_traffic` on the next cycle, and the reset still lasts the full `RST_CYCLES`.
- R9: Readback bits 5:4 hold {D+, D-} as registered one cycle earlier: 0 is SE0, 1 is K (D+ low, D- high), 2 is J (D+ high, D- low). The field resets to 3.
- R10: Readback bit 3 is the high-speed flag, registered one cycle after `hs_detect`. It resets to 0 and no write can change it. Bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Write data for the writable fields: bit 0 suspend, bit 1 force resume, bit 2 port reset |
| port_power | input | 1 | Port power is on |
| port_enable | input | 1 | Port is enabled |
| xfer_busy | input | 1 | A transaction is in progress on the bus |
| dp_level | input | 1 | Sampled D+ level |
| dm_level | input | 1 | Sampled D- level |
| hs_detect | input | 1 | Attached device runs at high speed |
| rd_data | output | 8 | Register readback |
| drive_reset | output | 1 | Request to drive bus reset |
| block_traffic | output | 1 | Gate downstream traffic |

## Verification
Several properties assume that port power stays high through the cycle in which they are judged. The bench removes power only in the power-loss scenario, and the properties that depend on power leave that case out. The line-status and high-speed properties treat `dp_level`, `dm_level` and `hs_detect` as synchronous inputs. The bench therefore changes them only on the falling clock edge. The deferral property expects `xfer_busy` to stay high for the whole cycle of the suspend write, and the bench keeps it high for several cycles around that write.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
    localparam int REG_W   = 8;
    localparam int WR_W    = 3;
    // readback and write field positions
    localparam int B_SUSP  = 0;
    localparam int B_FRES  = 1;
    localparam int B_PRST  = 2;
    localparam int B_HS    = 3;
    localparam int B_LS_LO = 4;
    localparam int B_LS_HI = 5;

    typedef enum logic {
        RT_IDLE,
        RT_DRIVE
    } rst_state_e;

    typedef enum logic [1:0] {
        SP_ACTIVE,
        SP_PENDING,
        SP_SUSPENDED
    } susp_state_e;
endpackage

// File: rtl/usbp_rst_timer.sv
module usbp_rst_timer
    import usbp_pkg::*;
#(
    parameter int RST_CYCLES = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power,
    input  logic start,
    output logic driving
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

    rst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!power) begin
            state_d = RT_IDLE;          // abort
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                RT_IDLE: begin
                    if (start) begin    // start
                        state_d = RT_DRIVE;
                        cnt_d   = LOAD;
                    end
                end
                RT_DRIVE: begin
                    if (cnt_q == '0) begin
                        state_d = RT_IDLE;  // expire
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        driving = (state_q == RT_DRIVE);
    end
endmodule

// File: rtl/usbp_susp_fsm.sv
module usbp_susp_fsm
    import usbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic power,
    input  logic enable,
    input  logic busy,
    input  logic resetting,
    input  logic susp_req,
    input  logic rst_req,
    input  logic resume_fall,
    output logic suspended,
    output logic blocked
);
    susp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!power || rst_req) begin
            state_d = SP_ACTIVE;                    // cancel
        end else begin
            unique case (state_q)
                SP_ACTIVE: begin
                    if (susp_req && enable && !resetting) begin
                        state_d = busy ? SP_PENDING   // defer
                                       : SP_SUSPENDED; // enter
                    end
                end
                SP_PENDING: begin
                    if (resume_fall)  state_d = SP_ACTIVE;     // resume
                    else if (!busy)   state_d = SP_SUSPENDED;  // settle
                end
                SP_SUSPENDED: begin
                    if (resume_fall)  state_d = SP_ACTIVE;     // resume
                end
                default: state_d = SP_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SP_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        suspended = (state_q == SP_SUSPENDED);
        blocked   = (state_q == SP_SUSPENDED);
    end
endmodule

// File: rtl/usbp_line_sync.sv
module usbp_line_sync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp,
    input  logic       dm,
    input  logic       hs_in,
    output logic [1:0] line_st,
    output logic       hs_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_st <= 2'b11;
            hs_out  <= 1'b0;
        end else begin
            line_st <= {dp, dm};
            hs_out  <= hs_in;
        end
    end
endmodule

// File: rtl/usb_port_ctl.sv
module usb_port_ctl
    import usbp_pkg::*;
#(
    parameter int RST_CYCLES = 600000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             port_power,
    input  logic             port_enable,
    input  logic             xfer_busy,
    input  logic             dp_level,
    input  logic             dm_level,
    input  logic             hs_detect,
    output logic [REG_W-1:0] rd_data,
    output logic             drive_reset,
    output logic             block_traffic
);
    logic fres_q;
    logic rst_req, susp_req, resume_fall;
    logic driving, suspended, blocked;
    logic [1:0] line_st;
    logic hs_q;

    always_comb begin
        rst_req     = wr_en && wr_data[B_PRST] && port_power;
        susp_req    = wr_en && wr_data[B_SUSP];
        resume_fall = wr_en && fres_q && !wr_data[B_FRES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           fres_q <= 1'b0;
        else if (!port_power) fres_q <= 1'b0;
        else if (wr_en)       fres_q <= wr_data[B_FRES];
    end

    usbp_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .power   (port_power),
        .start   (rst_req),
        .driving (driving)
    );

    usbp_susp_fsm u_susp (
        .clk         (clk),
        .rst_n       (rst_n),
        .power       (port_power),
        .enable      (port_enable),
        .busy        (xfer_busy),
        .resetting   (driving),
        .susp_req    (susp_req),
        .rst_req     (rst_req),
        .resume_fall (resume_fall),
        .suspended   (suspended),
        .blocked     (blocked)
    );

    usbp_line_sync u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .dp      (dp_level),
        .dm      (dm_level),
        .hs_in   (hs_detect),
        .line_st (line_st),
        .hs_out  (hs_q)
    );

    always_comb begin
        rd_data                 = '0;
        rd_data[B_SUSP]         = suspended && port_power;
        rd_data[B_FRES]         = fres_q;
        rd_data[B_PRST]         = driving && port_power;
        rd_data[B_HS]           = hs_q;
        rd_data[B_LS_HI:B_LS_LO] = line_st;
        drive_reset             = driving;
        block_traffic           = blocked;
    end
endmodule

// File: rtl/usbp_chk.sv
module usbp_chk
    import usbp_pkg::*;
#(
    parameter int RST_CYCLES = 600000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WR_W-1:0]  wr_data,
    input logic             port_power,
    input logic             port_enable,
    input logic             xfer_busy,
    input logic             dp_level,
    input logic             dm_level,
    input logic             hs_detect,
    input logic [REG_W-1:0] rd_data,
    input logic             drive_reset,
    input logic             block_traffic
);
    logic past_ok;
    int   run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            run_q   <= 0;
        end else begin
            past_ok <= 1'b1;
            run_q   <= drive_reset ? run_q + 1 : 0;
        end
    end

    // R1
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_PRST] && port_power && !drive_reset) |=> drive_reset);

    // R2
    rst_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_reset |-> (run_q < RST_CYCLES));

    // R2
    rst_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_reset) && port_power && $past(port_power)) |-> (run_q == RST_CYCLES));

    // R3
    power_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_power |-> (!rd_data[B_SUSP] && !rd_data[B_PRST]));

    // R5
    defer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_SUSP] && !wr_data[B_PRST] && xfer_busy && port_enable &&
         port_power && !block_traffic && !drive_reset) |=> !rd_data[B_SUSP]);

    // R6
    hold_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_SUSP] && wr_en && !wr_data[B_SUSP] && !wr_data[B_PRST] &&
         !(rd_data[B_FRES] && !wr_data[B_FRES])) |=> (rd_data[B_SUSP] || !port_power));

    // R8
    block_vs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_traffic |-> !drive_reset);

    // R9
    line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rd_data[B_LS_HI:B_LS_LO] == $past({dp_level, dm_level})));

    // R10
    hs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rd_data[B_HS] == $past(hs_detect) && rd_data[7:6] == 2'b00));
endmodule

bind usb_port_ctl usbp_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .port_power    (port_power),
    .port_enable   (port_enable),
    .xfer_busy     (xfer_busy),
    .dp_level      (dp_level),
    .dm_level      (dm_level),
    .hs_detect     (hs_detect),
    .rd_data       (rd_data),
    .drive_reset   (drive_reset),
    .block_traffic (block_traffic)
);

// File: tb/sim_usb_port_ctl.sv
module sim_usb_port_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int NRST = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = '0;
    logic       port_power = 1'b1;
    logic       port_enable = 1'b1;
    logic       xfer_busy = 1'b0;
    logic       dp_level = 1'b0;
    logic       dm_level = 1'b0;
    logic       hs_detect = 1'b0;
    logic [7:0] rd_data;
    logic       drive_reset;
    logic       block_traffic;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_port_ctl #(.RST_CYCLES(NRST)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .port_power(port_power), .port_enable(port_enable),
        .xfer_busy(xfer_busy), .dp_level(dp_level), .dm_level(dm_level),
        .hs_detect(hs_detect), .rd_data(rd_data),
        .drive_reset(drive_reset), .block_traffic(block_traffic)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write cycle; returns at the falling edge after the capturing edge
    task automatic wr(input logic [2:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // counts cycles that drive_reset stays high, starting at the current cycle
    task automatic count_reset(output int len);
        len = 0;
        while (drive_reset && len < 10 * NRST) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk("R9 reset value of readback", int'(rd_data), 'h30);
        chk("R1 drive_reset low in reset", int'(drive_reset), 0);
        rst_n = 1'b1;
        idle(1);
        chk("R9 line follows SE0 after reset", int'(rd_data[5:4]), 0);
    endtask

    task automatic t_port_reset;
        int len;
        wr(3'b100);
        chk("R1 drive_reset after write", int'(drive_reset), 1);
        chk("R1 reset bit reads 1", int'(rd_data[2]), 1);
        idle(2);
        wr(3'b000);
        chk("R2 zero write keeps reset running", int'(rd_data[2]), 1);
        idle(1);
        count_reset(len);
        chk("R2 reset length", len + 5, NRST);
        chk("R2 reset bit self-clears", int'(rd_data[2]), 0);
    endtask

    task automatic t_power_off;
        wr(3'b100);
        idle(2);
        port_power = 1'b0;
        #1;
        chk("R3 reset bit masked when unpowered", int'(rd_data[2]), 0);
        idle(1);
        chk("R3 reset aborted", int'(drive_reset), 0);
        port_power = 1'b1;
        idle(1);
        chk("R3 reset stays aborted", int'(rd_data[2]), 0);
        wr(3'b001);
        chk("R4 suspend before power loss", int'(rd_data[0]), 1);
        port_power = 1'b0;
        #1;
        chk("R3 suspend bit masked when unpowered", int'(rd_data[0]), 0);
        idle(1);
        port_power = 1'b1;
        idle(1);
        chk("R3 suspend state cleared by power loss", int'(rd_data[0]), 0);
        chk("R3 block cleared by power loss", int'(block_traffic), 0);
    endtask

    task automatic t_suspend_idle;
        chk("R4 not suspended before", int'(block_traffic), 0);
        wr(3'b001);
        chk("R4 suspend bit", int'(rd_data[0]), 1);
        chk("R4 block asserted", int'(block_traffic), 1);
    endtask

    task automatic t_write_zero_fres;
        wr(3'b000);
        chk("R6 zero write keeps suspend", int'(rd_data[0]), 1);
        wr(3'b010);
        chk("R6 setting force resume keeps suspend", int'(rd_data[0]), 1);
        chk("R6 force resume bit reads 1", int'(rd_data[1]), 1);
        wr(3'b000);
        chk("R6 force resume fall clears suspend", int'(rd_data[0]), 0);
        chk("R6 block released", int'(block_traffic), 0);
    endtask

    task automatic t_suspend_busy;
        @(negedge clk);
        xfer_busy = 1'b1;
        wr(3'b001);
        chk("R5 suspend deferred while busy", int'(rd_data[0]), 0);
        idle(3);
        chk("R5 still deferred", int'(block_traffic), 0);
        xfer_busy = 1'b0;
        #1;
        chk("R5 not yet suspended at busy fall", int'(rd_data[0]), 0);
        idle(1);
        chk("R5 suspended after busy ends", int'(rd_data[0]), 1);
        chk("R5 block after busy ends", int'(block_traffic), 1);
        wr(3'b010);
        wr(3'b000);
        // pending suspend cancelled by resume
        xfer_busy = 1'b1;
        wr(3'b001);
        wr(3'b010);
        wr(3'b000);
        xfer_busy = 1'b0;
        idle(2);
        chk("R6 resume cancels pending suspend", int'(rd_data[0]), 0);
    endtask

    task automatic t_disabled;
        port_enable = 1'b0;
        wr(3'b001);
        idle(1);
        chk("R7 suspend ignored when disabled", int'(rd_data[0]), 0);
        chk("R7 no block when disabled", int'(block_traffic), 0);
        port_enable = 1'b1;
        idle(1);
        chk("R7 request not remembered", int'(rd_data[0]), 0);
    endtask

    task automatic t_reset_in_suspend;
        int len;
        wr(3'b001);
        chk("R8 suspended first", int'(rd_data[0]), 1);
        wr(3'b100);
        chk("R8 reset clears suspend", int'(rd_data[0]), 0);
        chk("R8 block cleared by reset", int'(block_traffic), 0);
        chk("R8 reset driven while leaving suspend", int'(drive_reset), 1);
        count_reset(len);
        chk("R8 full reset length", len, NRST);
        xfer_busy = 1'b1;
        wr(3'b001);
        wr(3'b100);
        xfer_busy = 1'b0;
        idle(2);
        chk("R8 reset cancels pending suspend", int'(rd_data[0]), 0);
        count_reset(len);
    endtask

    task automatic t_line_status;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            dp_level = i[1];
            dm_level = i[0];
            @(negedge clk);
            chk("R9 line status code", int'(rd_data[5:4]), i);
        end
    endtask

    task automatic t_hs;
        @(negedge clk);
        hs_detect = 1'b1;
        #1;
        chk("R10 hs not yet registered", int'(rd_data[3]), 0);
        @(negedge clk);
        chk("R10 hs bit set", int'(rd_data[3]), 1);
        wr(3'b000);
        chk("R10 write leaves hs", int'(rd_data[3]), 1);
        chk("R10 upper bits zero", int'(rd_data[7:6]), 0);
        hs_detect = 1'b0;
        idle(1);
        chk("R10 hs bit clear", int'(rd_data[3]), 0);
    endtask

    initial begin
        t_reset_state();
        t_port_reset();
        t_power_off();
        t_suspend_idle();
        t_write_zero_fres();
        t_suspend_busy();
        t_disabled();
        t_reset_in_suspend();
        t_line_status();
        t_hs();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule